// File: doc/BRIEF.md
# Triangular Chirp Two-Point Modulator

This block produces the digital modulation sequence for a chirp frequency synthesizer. It computes one new sample on every reference clock edge. The sample follows a triangle: from a programmed start value it climbs by a fixed signed increment for a programmed number of steps, then falls by the same increment for the same number of steps, and then repeats.

Each sample goes to both injection points of a two-point modulation loop. The direct path multiplies the sample by a signed fixed-point gain and saturates the result to the oscillator tuning width. That value is added to the oscillator tuning word. The feedback path carries the negated sample, which is added to the divider frequency-control word. When the gain equals the reference frequency divided by the oscillator gain, the two paths together give a flat modulation response. A direction flag reports which half of the triangle is being generated. Pulling the enable low parks both paths at zero and rearms the ramp at its start value.

Top module: `tpm_chirp_gen`

## Requirements
- R1: During and straight after reset, `tune_out`, `fb_out` and `dir_dn` are all zero.
- R2: The sample after a clock edge that sees `en` low reads zero on `tune_out`, `fb_out` and `dir_dn`. The first sample after `en` goes high is always `ramp_start`, even if the ramp was stopped part-way.
- R3: In the rising half, each sample equals the previous sample plus `ramp_step`, and `dir_dn` is 0.
- R4: Counting the first enabled sample as index 0, let p = index mod 2N, where N is `ramp_len`. The sample is `ramp_start + p*ramp_step` for p <= N and `ramp_start + (2N-p)*ramp_step` otherwise. `dir_dn` is 1 exactly when p >= N, so the triangle period is 2N samples.
- R5: A `ramp_len` of 0 behaves like 1: the ramp reverses after every step.
- R6: `fb_out` equals the negated modulation sample. When the sample is the most negative code, `fb_out` saturates to the most positive code.
- R7: `tune_out` equals (sample × `gain`) shifted right arithmetically by GF bits (rounding toward minus infinity). `gain` is a signed value with GF fractional bits (default 8, so 256 means 1.0).
- R8: When the scaled product is outside the signed TW-bit range, `tune_out` clamps to the nearest end of that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one modulation sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the ramp when high; parks outputs at zero when low |
| ramp_start | input | MW | Signed first sample and trough of the triangle |
| ramp_step | input | MW | Signed increment per sample in the rising half |
| ramp_len | input | CW | Steps per half-period (0 treated as 1) |
| gain | input | GW | Signed direct-path gain, GF fractional bits |
| tune_out | output | TW | Saturated, gain-scaled sample for the oscillator tuning word |
| fb_out | output | MW | Negated sample for the feedback frequency-control word |
| dir_dn | output | 1 | High while the ramp is descending |

## Verification
The in-line properties assume two things about the inputs. First, `ramp_start`, `ramp_step`, `ramp_len` and `gain` stay constant while `en` is high. Second, the triangle peak `ramp_start + N*ramp_step` fits in MW signed bits, so the ramp register never wraps. The step-law and counter-bound properties are only meaningful under these conditions. The directed stimulus changes configuration only while `en` is low and picks starts and increments whose peaks stay inside the range. Saturation is reached only through the gain product and through negation of the most negative code.

// File: rtl/tpm_chirp_gen.sv
module tpm_chirp_gen #(
  parameter int MW = 16,
  parameter int GW = 12,
  parameter int GF = 8,
  parameter int TW = 16,
  parameter int CW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [MW-1:0] ramp_start,
  input  logic signed [MW-1:0] ramp_step,
  input  logic        [CW-1:0] ramp_len,
  input  logic signed [GW-1:0] gain,
  output logic signed [TW-1:0] tune_out,
  output logic signed [MW-1:0] fb_out,
  output logic                 dir_dn
);
  localparam int PW = MW + GW;
  localparam logic signed [PW-1:0] TMAX = PW'((64'sd1 <<< (TW-1)) - 1);
  localparam logic signed [PW-1:0] TMIN = -TMAX - 1;
  localparam logic signed [MW-1:0] MMIN = {1'b1, {(MW-1){1'b0}}};
  localparam logic signed [MW-1:0] MMAX = {1'b0, {(MW-1){1'b1}}};

  logic signed [MW-1:0] m;
  logic [CW-1:0] cnt;
  logic dir, run;

  wire last = ({1'b0, cnt} + 1'b1) >= {1'b0, ramp_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m <= '0; cnt <= '0; dir <= 1'b0; run <= 1'b0;
    end else if (!en || !run) begin
      run <= en;
      m   <= ramp_start;
      cnt <= '0;
      dir <= 1'b0;
    end else begin
      m <= dir ? m - ramp_step : m + ramp_step;
      if (last) begin
        cnt <= '0;
        dir <= ~dir;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic signed [PW-1:0] prod, scaled;
  logic signed [TW-1:0] tune_sat;
  logic signed [MW-1:0] neg;

  assign prod   = $signed(m) * $signed(gain);
  assign scaled = prod >>> GF;
  assign tune_sat = (scaled > TMAX) ? TMAX[TW-1:0] :
                    (scaled < TMIN) ? TMIN[TW-1:0] : scaled[TW-1:0];
  assign neg = (m == MMIN) ? MMAX : -m;

  assign tune_out = run ? tune_sat : '0;
  assign fb_out   = run ? neg : '0;
  assign dir_dn   = run & dir;

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tune_out == '0 && fb_out == '0 && !dir_dn));

  p_rise_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && !dir) |=> (m == $past(m) + $past(ramp_step)));

  p_fall_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && dir) |=> (m == $past(m) - $past(ramp_step)));

  p_hold_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && !last) |=> $stable(dir));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(ramp_len) && ramp_len != '0) |-> (cnt < ramp_len));

  p_fb_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && m != '0 && m != MMIN) |-> (fb_out[MW-1] != m[MW-1]));

  p_tune_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && m > 0 && gain > 0) |-> (tune_out >= 0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && m < 0 && gain > 0) |-> (tune_out <= 0));
endmodule

// File: tb/sim_tpm_chirp_gen.sv
`timescale 1ns/1ps
module sim_tpm_chirp_gen;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic signed [15:0] ramp_start = '0, ramp_step = '0;
  logic [9:0] ramp_len = '0;
  logic signed [11:0] gain = '0;
  logic signed [15:0] tune_out, fb_out;
  logic dir_dn;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  tpm_chirp_gen u0 (.clk(clk), .rst_n(rst_n), .en(en), .ramp_start(ramp_start),
    .ramp_step(ramp_step), .ramp_len(ramp_len), .gain(gain),
    .tune_out(tune_out), .fb_out(fb_out), .dir_dn(dir_dn));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint exp_tune(input longint mv, input longint g);
    longint p = mv * g;
    return sat16(p >>> 8);
  endfunction

  function automatic longint exp_mod(input longint s, input longint d, input int n, input int i);
    int p = i % (2 * n);
    return (p <= n) ? s + p * d : s + (2 * n - p) * d;
  endfunction

  task automatic stop_and_check(input string req);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk({req, " tune idle"}, tune_out, 0);
    chk({req, " fb idle"}, fb_out, 0);
    chk({req, " dir idle"}, dir_dn, 0);
  endtask

  task automatic run_ramp(input string req, input int s, input int d, input int len,
                          input int g, input int samples);
    int n = (len == 0) ? 1 : len;
    @(negedge clk);
    ramp_start = 16'(s); ramp_step = 16'(d); ramp_len = 10'(len); gain = 12'(g);
    en = 1'b1;
    for (int i = 0; i < samples; i++) begin
      longint mv = exp_mod(s, d, n, i);
      @(negedge clk);
      chk({req, " fb"}, fb_out, sat16(-mv));
      chk({req, " tune"}, tune_out, exp_tune(mv, g));
      chk({req, " dir"}, dir_dn, ((i % (2 * n)) >= n) ? 1 : 0);
    end
    stop_and_check({req, " R2"});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 tune", tune_out, 0);
    chk("R1 fb", fb_out, 0);
    chk("R1 dir", dir_dn, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tune after release", tune_out, 0);
  endtask

  task automatic t_restart();
    @(negedge clk);
    ramp_start = 16'sd300; ramp_step = 16'sd10; ramp_len = 10'd5; gain = 12'sd256;
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 mid ramp", fb_out, -330);
    stop_and_check("R2 mid stop");
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    chk("R2 restart at start", tune_out, 300);
    chk("R2 restart dir", dir_dn, 0);
    stop_and_check("R2 second stop");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    run_ramp("R3 R4 unity gain", 100, 25, 3, 256, 14);
    run_ramp("R4 negative step", -50, -7, 4, 256, 17);
    run_ramp("R7 gain -1.5", 123, 31, 3, -384, 13);
    run_ramp("R7 gain 0.75 floor", -77, 13, 2, 192, 9);
    run_ramp("R5 len zero", 40, 9, 0, 256, 6);
    run_ramp("R5 len one", 40, 9, 1, 256, 6);
    run_ramp("R8 clamp high", 20000, 100, 2, 2047, 6);
    run_ramp("R8 clamp low", -20000, -100, 2, 2047, 6);
    run_ramp("R6 most negative", -32768, 0, 2, 256, 4);
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule